// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is a bank of 24 general-purpose pins on a 32-bit register bus. Each pin is an input or an output, set by its own direction bit. Output values are held in a data register. That register can be written whole, or changed one bit at a time through separate set, clear and toggle offsets. These offsets change only the bits written as 1, so software needs no read-modify-write sequence and two agents cannot overwrite each other's bits.

Input pins pass through a two-stage synchronizer. A per-pin polarity bit can then invert the pin. Each pin has its own tracker: a two-state machine with the states LVL_LOW and LVL_HIGH. The move from LVL_LOW to LVL_HIGH is the RISE transition, and the move back is the FALL transition. The trackers follow the polarity-adjusted level, so inverting a pin also swaps which physical edge counts as rising.

A transition that is enabled for its direction latches the pin's interrupt-pending bit. It also records the direction of that edge in a per-pin edge-kind register. The interrupt line is high while any pending bit is set, and software acknowledges a pending bit by writing 1 to it.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every register reads 0, and pin_out, pin_oe and irq are 0.
- R2: pin_oe equals the direction register at offset 0x24. A direction bit of 1 makes that pin an output.
- R3: A write to offset 0x20 loads pin_out. A read of 0x20 returns the pin_out bit for every pin whose direction bit is 1.
- R4: Writing offset 0x2C sets the output bits that are 1 in the written value. Writing 0x30 clears them, and writing 0x34 inverts them. Every other output bit keeps its value.
- R5: For a pin whose direction bit is 0, a read of 0x20 returns the synchronized pin level XOR the polarity bit at offset 0x28.
- R6: When rising detection is enabled for a pin (offset 0x08), a 0-to-1 change of its adjusted level sets its pending bit (offset 0x00) and sets its edge-kind bit (offset 0x04) to 1.
- R7: When falling detection is enabled for a pin (offset 0x0C), a 1-to-0 change of its adjusted level sets its pending bit and sets its edge-kind bit to 0.
- R8: An edge whose direction is not enabled leaves the pending bit, the edge-kind bit and irq unchanged.
- R9: Writing 1 to a bit at offset 0x00 clears that pending bit. Bits written 0 and the edge-kind register are unaffected.
- R10: irq is 1 exactly when at least one pending bit is set.
- R11: Edge detection acts on the polarity-adjusted level. With the polarity bit at 1, a physical falling edge is a rising edge.
- R12: Offsets not listed above read 0, and writes to them change nothing. Bits 31:24 of every read are 0.
- R13: If an enabled edge occurs in the same cycle as a write-1 acknowledge of that pin, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 24 | Pin levels from the pads |
| pin_out | output | 24 | Output values driven to the pads |
| pin_oe | output | 24 | Output enable per pin |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the collision of R13, where an acknowledge write lands in the exact cycle that a new enabled edge sets the same pending bit. From the ports, this means counting the synchronizer stages and the tracker register. The bench changes one pin at a falling clock edge, lets two rising edges pass, and then holds the write-1 strobe for the third rising edge. In that same write it acknowledges a second pin whose bit was already pending, so the check shows both that the acknowledge took effect and that the new edge won.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam logic [7:0] OFS_PEND    = 8'h00;
    localparam logic [7:0] OFS_KIND    = 8'h04;
    localparam logic [7:0] OFS_RISE_EN = 8'h08;
    localparam logic [7:0] OFS_FALL_EN = 8'h0C;
    localparam logic [7:0] OFS_DATA    = 8'h20;
    localparam logic [7:0] OFS_DIR     = 8'h24;
    localparam logic [7:0] OFS_POL     = 8'h28;
    localparam logic [7:0] OFS_SET     = 8'h2C;
    localparam logic [7:0] OFS_CLR     = 8'h30;
    localparam logic [7:0] OFS_TGL     = 8'h34;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD,
        OP_SET,
        OP_CLR,
        OP_TGL
    } out_op_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;
endmodule

// File: rtl/gpio_pin_edge.sv
module gpio_pin_edge
    import gpio_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    lvl_state_t state_q;
    lvl_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (lvl)  state_d = LVL_HIGH;
            LVL_HIGH: if (!lvl) state_d = LVL_LOW;
        endcase
    end

    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state_q)
            LVL_LOW:  rise = lvl;
            LVL_HIGH: fall = !lvl;
        endcase
    end

    assert_rise_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (state_q == LVL_HIGH));
    assert_fall_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (state_q == LVL_LOW));
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive
    import gpio_bank_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  out_op_t      op,
    input  logic [W-1:0] wval,
    output logic [W-1:0] out_q
);
    logic [W-1:0] out_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    always_comb begin
        out_d = out_q;
        unique case (op)
            OP_NONE: out_d = out_q;
            OP_LOAD: out_d = wval;
            OP_SET:  out_d = out_q | wval;
            OP_CLR:  out_d = out_q & ~wval;
            OP_TGL:  out_d = out_q ^ wval;
            default: out_d = out_q;
        endcase
    end

    assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SET) |=> ((out_q & $past(wval)) == $past(wval)));
    assert_clr_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLR) |=> ((out_q & $past(wval)) == '0));
    assert_tgl_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_TGL) |=> ((out_q & ~$past(wval)) == ($past(out_q) & ~$past(wval))));
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int PINS = 24,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe,
    output logic            irq
);
    localparam int PAD = DW - PINS;

    logic [PINS-1:0] wd;
    logic            unused_upper;
    assign wd           = bus_wdata[PINS-1:0];
    assign unused_upper = ^bus_wdata[DW-1:PINS];

    logic [PINS-1:0] dir_q, pol_q, rise_en_q, fall_en_q, pend_q, kind_q;
    logic [PINS-1:0] pin_sync, lvl, rise_v, fall_v, hit;
    logic [PINS-1:0] out_q, rsel;
    out_op_t         op;

    function automatic logic wr_at(input logic [7:0] ofs);
        return bus_wr && (bus_addr == AW'(ofs));
    endfunction

    gpio_sync #(.W(PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .d_sync  (pin_sync)
    );

    assign lvl = pin_sync ^ pol_q;

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        gpio_pin_edge u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (lvl[i]),
            .rise  (rise_v[i]),
            .fall  (fall_v[i])
        );
    end

    assign hit = (rise_v & rise_en_q) | (fall_v & fall_en_q);

    always_comb begin
        op = OP_NONE;
        if      (wr_at(OFS_DATA)) op = OP_LOAD;
        else if (wr_at(OFS_SET))  op = OP_SET;
        else if (wr_at(OFS_CLR))  op = OP_CLR;
        else if (wr_at(OFS_TGL))  op = OP_TGL;
    end

    gpio_drive #(.W(PINS)) u_drive (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .wval  (wd),
        .out_q (out_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q     <= '0;
            pol_q     <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else begin
            if (wr_at(OFS_DIR))     dir_q     <= wd;
            if (wr_at(OFS_POL))     pol_q     <= wd;
            if (wr_at(OFS_RISE_EN)) rise_en_q <= wd;
            if (wr_at(OFS_FALL_EN)) fall_en_q <= wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            kind_q <= '0;
        end else begin
            pend_q <= (pend_q & ~(wr_at(OFS_PEND) ? wd : '0)) | hit;
            kind_q <= (kind_q & ~hit) | (hit & rise_v);
        end
    end

    always_comb begin
        rsel = '0;
        case (bus_addr)
            AW'(OFS_PEND):    rsel = pend_q;
            AW'(OFS_KIND):    rsel = kind_q;
            AW'(OFS_RISE_EN): rsel = rise_en_q;
            AW'(OFS_FALL_EN): rsel = fall_en_q;
            AW'(OFS_DATA):    rsel = (dir_q & out_q) | (~dir_q & lvl);
            AW'(OFS_DIR):     rsel = dir_q;
            AW'(OFS_POL):     rsel = pol_q;
            default:          rsel = '0;
        endcase
    end

    assign bus_rdata = {{PAD{1'b0}}, rsel};
    assign pin_out   = out_q;
    assign pin_oe    = dir_q;
    assign irq       = |pend_q;

    assert_no_spurious_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pend_q & ~$past(pend_q)) & ~$past(hit)) == '0));
    assert_edge_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((pend_q & $past(hit)) == $past(hit)));
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFS_PEND)) |=>
        ((pend_q & $past(wd) & ~$past(hit)) == '0));
    assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> irq);
endmodule

// File: tb/sim_gpio_edge_bank.sv
module sim_gpio_edge_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [23:0] pin_in = '0;
    logic [23:0] pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    gpio_edge_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_pins(input logic [23:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(posedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] r;
        foreach (r[i]) r[i] = 1'b0;
        for (int a = 0; a < 'h38; a += 4) begin
            rd(8'(a), r);
            check("R1 register reset", r, 32'h0);
        end
        check("R1 pin_out", {8'h0, pin_out}, 32'h0);
        check("R1 pin_oe", {8'h0, pin_oe}, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_dir_data();
        logic [31:0] r;
        wr(8'h24, 32'h00FF00FF);
        check("R2 pin_oe", {8'h0, pin_oe}, 32'h00FF00FF);
        wr(8'h20, 32'h00123456);
        check("R3 pin_out", {8'h0, pin_out}, 32'h00123456);
        rd(8'h20, r);
        check("R3 data readback", r, 32'h00123456 & 32'h00FF00FF);
    endtask

    task automatic t_atomic();
        logic [23:0] e;
        wr(8'h20, 32'h000F0F0F); e = 24'h0F0F0F;
        wr(8'h2C, 32'h00300030); e = e | 24'h300030;
        check("R4 set", {8'h0, pin_out}, {8'h0, e});
        wr(8'h30, 32'h00000F01); e = e & ~24'h000F01;
        check("R4 clear", {8'h0, pin_out}, {8'h0, e});
        wr(8'h34, 32'h00FFFFFF); e = ~e;
        check("R4 toggle", {8'h0, pin_out}, {8'h0, e});
        wr(8'h34, 32'h00000001); e = e ^ 24'h1;
        check("R4 toggle one bit", {8'h0, pin_out}, {8'h0, e});
    endtask

    task automatic t_input_pol();
        logic [31:0] r;
        wr(8'h24, 32'h0);
        set_pins(24'hA5A5A5);
        rd(8'h20, r);
        check("R5 input read", r, 32'h00A5A5A5);
        wr(8'h28, 32'h000000FF);
        rd(8'h20, r);
        check("R5 polarity read", r, 32'h00A5A55A);
        rd(8'h00, r);
        check("R8 no enable no pend", r, 32'h0);
        wr(8'h28, 32'h0);
        set_pins(24'h0);
    endtask

    task automatic t_rise_fall();
        logic [31:0] r;
        wr(8'h08, 32'h00000103);
        set_pins(24'h000101);
        rd(8'h00, r); check("R6 pend on rise", r, 32'h101);
        rd(8'h04, r); check("R6 kind rise", r, 32'h101);
        check("R10 irq set", {31'h0, irq}, 32'h1);
        set_pins(24'h000000);
        rd(8'h00, r); check("R8 fall not enabled", r, 32'h101);
        rd(8'h04, r); check("R8 kind unchanged", r, 32'h101);
        wr(8'h00, 32'h00000001);
        rd(8'h00, r); check("R9 ack one bit", r, 32'h100);
        rd(8'h04, r); check("R9 kind kept", r, 32'h101);
        check("R10 irq still set", {31'h0, irq}, 32'h1);
        wr(8'h00, 32'h00000100);
        check("R10 irq clear", {31'h0, irq}, 32'h0);
        wr(8'h0C, 32'h00000002);
        set_pins(24'h000002);
        wr(8'h00, 32'h00FFFFFF);
        rd(8'h04, r); check("R6 kind bit1 rise", r & 32'h2, 32'h2);
        set_pins(24'h000000);
        rd(8'h00, r); check("R7 pend on fall", r, 32'h2);
        rd(8'h04, r); check("R7 kind fall", r & 32'h2, 32'h0);
        wr(8'h00, 32'h00FFFFFF);
        wr(8'h08, 32'h0); wr(8'h0C, 32'h0);
    endtask

    task automatic t_pol_edge();
        logic [31:0] r;
        set_pins(24'h000004);
        wr(8'h28, 32'h00000004);
        repeat (4) @(posedge clk);
        wr(8'h08, 32'h00000004);
        set_pins(24'h000000);
        rd(8'h00, r); check("R11 inverted fall is rise", r, 32'h4);
        rd(8'h04, r); check("R11 kind rise", r & 32'h4, 32'h4);
        wr(8'h08, 32'h0);
        wr(8'h28, 32'h0);
        repeat (4) @(posedge clk);
        wr(8'h00, 32'h00FFFFFF);
        rd(8'h00, r); check("R11 clean", r, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] r;
        wr(8'h08, 32'h00000018);
        set_pins(24'h000008);
        @(negedge clk);
        pin_in = 24'h000018;
        @(posedge clk);
        @(posedge clk);
        wr(8'h00, 32'h00000018);
        rd(8'h00, r); check("R13 edge beats ack", r, 32'h10);
        wr(8'h00, 32'h00000010);
        rd(8'h00, r); check("R9 later ack", r, 32'h0);
        wr(8'h08, 32'h0);
        set_pins(24'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] r;
        wr(8'h24, 32'h00000F0F);
        wr(8'h10, 32'hFFFFFFFF);
        rd(8'h10, r); check("R12 unmapped read", r, 32'h0);
        rd(8'h24, r); check("R12 unmapped write no effect", r, 32'h00000F0F);
        wr(8'h24, 32'hFFFFFFFF);
        rd(8'h24, r); check("R12 upper bits zero", r, 32'h00FFFFFF);
        check("R2 pin_oe all", {8'h0, pin_oe}, 32'h00FFFFFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_dir_data();
        t_atomic();
        t_input_pol();
        t_rise_fall();
        t_pol_edge();
        t_collision();
        t_unmapped();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule